// File: doc/BRIEF.md
# Circular Buffer Word Streamer

This block feeds a serial transmitter from a ring of 32-bit sample words held in memory. The consumer raises a request line, and the streamer makes exactly one read from memory at its current source address. On the next cycle it hands the word to the consumer with a one-cycle acknowledge. The source address then moves up by four bytes. After the last word of the ring, the address drops back by the ring size, so it returns to the base, and the word count reloads. The destination is a fixed port, so no destination address is kept.

Samples are stored with the channels interleaved: word `CHANNELS*i + c` holds channel `c` of frame `i`. The streamer delivers words strictly in address order, so this layout reaches the serializer unchanged. Two sticky flags let software double-buffer the ring. The half flag rises when half of the pass has been sent, and the full flag rises when the pass wraps. Software refills whichever half is idle. To find the idle half, it reads the live source address and compares it with base plus half the length.

Top module: `cbs_streamer`

## Requirements
- R1: After reset the block is disabled, both flags are 0, `consumerAck` and `memRdEn` are 0, and the current-address register reads 0.
- R2: Register select 0 is the ring base (byte address) and select 1 is the ring length in bytes; both read back as written. Select 2 bit 0 is the enable bit. Select 3 is the status register: bit 0 is the half flag and bit 1 is the full flag. Select 4 is the current source address. Any other select reads 0.
- R3: When the block is enabled, idle, and sees `consumerReq` high, it asserts `memRdEn` in that cycle with `memAddr` equal to the current address. In the next cycle it asserts `consumerAck` for one cycle, with `consumerData` equal to the word the memory returned.
- R4: Each transfer advances the current address by 4, so the words of a pass come out in ascending address order.
- R5: The transfer that completes length/4 words moves the address back by the length, to the base, and reloads the count. The next pass repeats the same sequence.
- R6: The half flag sets on the transfer that leaves exactly (length/4)/2 words remaining in the pass, and never on the last word of a pass.
- R7: The full flag sets on the last transfer of each pass.
- R8: The flags are sticky. Writing a 1 to a status bit clears that flag. Writing a 0 leaves it unchanged.
- R9: If a flag's event and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R10: While the enable bit is 0, requests are ignored: there is no memory read and no acknowledge, and the current address does not change.
- R11: Writing enable=1 while the block is disabled reloads the current address to the base and the count to length/4, so a pass interrupted by disabling restarts from the base.
- R12: Writes to the current-address register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regSel) |
| consumerReq | input | 1 | Word request from the serializer |
| consumerAck | output | 1 | One-cycle acknowledge; data valid |
| consumerData | output | 32 | Word handed to the serializer |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | AW | Memory byte address |
| memRdData | input | 32 | Memory data, valid the cycle after memRdEn |
| irqHalf | output | 1 | Sticky half-pass flag |
| irqFull | output | 1 | Sticky end-of-pass flag |

## Verification
Suppose the word count is wrong. The wrap address and the full flag then appear on the wrong transfer, and the bench sees this within one pass, because it checks `memAddr` and both flags after every acknowledged word. A wrong address step or wrap target shows up as a wrong `memAddr` on the very next request, and as a wrong memory word on the acknowledge in the cycle after it. Faulty flag or enable handling shows on the status read taken right after each write or transfer.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int REG_W = 32;
  localparam int DATA_W = 32;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_BASE   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_LEN    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CUR    = 3'd4;

  typedef struct packed {
    logic issueRd;
    logic advance;
    logic restart;
  } ctlStrobes_t;
endpackage

// File: rtl/cbs_datapath.sv
module cbs_datapath
  import cbs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic          baseWr,
  input  logic          lenWr,
  input  logic [AW-1:0] wrData,
  output logic [AW-1:0] baseAddr,
  output logic [AW-1:0] lenBytes,
  output logic [AW-1:0] curAddr,
  output logic          lastWord,
  output logic          halfHit
);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic [AW-1:0] wordCount;
  logic [AW-1:0] wordsTotal;
  logic [AW-1:0] halfMark;

  assign wordsTotal = lenBytes >> 2;
  assign halfMark   = wordsTotal >> 1;
  assign lastWord   = (wordCount == ONE);
  assign halfHit    = !lastWord && ((wordCount - ONE) == halfMark);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      lenBytes <= '0;
    end else begin
      if (baseWr) baseAddr <= wrData;
      if (lenWr)  lenBytes <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      wordCount <= '0;
    end else if (strobes.restart) begin
      curAddr   <= baseAddr;
      wordCount <= wordsTotal;
    end else if (strobes.advance) begin
      if (lastWord) begin
        curAddr   <= curAddr + STEP - lenBytes;
        wordCount <= wordsTotal;
      end else begin
        curAddr   <= curAddr + STEP;
        wordCount <= wordCount - ONE;
      end
    end
  end

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.restart && !lastWord) |=> curAddr == $past(curAddr) + STEP);

  p_wrap_back_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.restart && lastWord)
      |=> curAddr == $past(curAddr) + STEP - $past(lenBytes));

  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.restart) |=> $stable(curAddr));
endmodule

// File: rtl/cbs_control.sv
module cbs_control
  import cbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWr,
  input  logic        statusWr,
  input  logic [1:0]  wrBits,
  input  logic        consumerReq,
  input  logic        lastWord,
  input  logic        halfHit,
  output ctlStrobes_t strobes,
  output logic        enable,
  output logic        halfFlag,
  output logic        fullFlag,
  output logic        ackOut
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t state;

  logic halfEv, fullEv, clrHalf, clrFull;

  always_comb begin
    strobes.issueRd = (state == ST_IDLE) && enable && consumerReq;
    strobes.advance = (state == ST_WAIT);
    strobes.restart = ctrlWr && wrBits[0] && !enable;
  end

  assign ackOut  = (state == ST_WAIT);
  assign halfEv  = strobes.advance && halfHit;
  assign fullEv  = strobes.advance && lastWord;
  assign clrHalf = statusWr && wrBits[0];
  assign clrFull = statusWr && wrBits[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      enable   <= 1'b0;
      halfFlag <= 1'b0;
      fullFlag <= 1'b0;
    end else begin
      state    <= strobes.issueRd ? ST_WAIT : ST_IDLE;
      if (ctrlWr) enable <= wrBits[0];
      halfFlag <= (halfFlag && !clrHalf) || halfEv;
      fullFlag <= (fullFlag && !clrFull) || fullEv;
    end
  end

  p_ack_after_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueRd |=> ackOut);

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);

  p_sticky_half_r8: assert property (@(posedge clk) disable iff (!rstN)
    (halfFlag && !clrHalf) |=> halfFlag);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fullEv && clrFull) |=> fullFlag);

  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !ackOut) |=> !ackOut);
endmodule

// File: rtl/cbs_streamer.sv
module cbs_streamer
  import cbs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              consumerReq,
  output logic              consumerAck,
  output logic [DATA_W-1:0] consumerData,
  output logic              memRdEn,
  output logic [AW-1:0]     memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              irqHalf,
  output logic              irqFull
);
  ctlStrobes_t strobes;
  logic [AW-1:0] baseAddr, lenBytes, curAddr;
  logic lastWord, halfHit, enable, halfFlag, fullFlag;

  cbs_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWr(regWrEn && regSel == SEL_CTRL),
    .statusWr(regWrEn && regSel == SEL_STATUS),
    .wrBits(regWrData[1:0]),
    .consumerReq(consumerReq),
    .lastWord(lastWord), .halfHit(halfHit),
    .strobes(strobes), .enable(enable),
    .halfFlag(halfFlag), .fullFlag(fullFlag),
    .ackOut(consumerAck)
  );

  cbs_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .baseWr(regWrEn && regSel == SEL_BASE),
    .lenWr(regWrEn && regSel == SEL_LEN),
    .wrData(regWrData[AW-1:0]),
    .baseAddr(baseAddr), .lenBytes(lenBytes), .curAddr(curAddr),
    .lastWord(lastWord), .halfHit(halfHit)
  );

  assign memRdEn      = strobes.issueRd;
  assign memAddr      = curAddr;
  assign consumerData = memRdData;
  assign irqHalf      = halfFlag;
  assign irqFull      = fullFlag;

  always_comb begin
    case (regSel)
      SEL_BASE:   regRdData = REG_W'(baseAddr);
      SEL_LEN:    regRdData = REG_W'(lenBytes);
      SEL_CTRL:   regRdData = REG_W'(enable);
      SEL_STATUS: regRdData = REG_W'({fullFlag, halfFlag});
      SEL_CUR:    regRdData = REG_W'(curAddr);
      default:    regRdData = '0;
    endcase
  end

  p_addr_port_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> $stable(memAddr));
endmodule

// File: tb/tb_cbs_streamer.sv
module tb_cbs_streamer;
  localparam int AW = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic consumerReq = 1'b0;
  logic consumerAck;
  logic [31:0] consumerData;
  logic memRdEn;
  logic [AW-1:0] memAddr;
  logic [31:0] memRdData = '0;
  logic irqHalf, irqFull;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cbs_streamer #(.AW(AW)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .consumerReq(consumerReq), .consumerAck(consumerAck),
    .consumerData(consumerData), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .irqHalf(irqHalf), .irqFull(irqFull)
  );

  function automatic logic [31:0] memWord(input logic [AW-1:0] a);
    return 32'hA000_0000 | 32'(a >> 2);
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memWord(memAddr);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] sel, output logic [31:0] d);
    regSel = sel;
    #1;
    d = regRdData;
  endtask

  // One transfer; optional status write lands in the advance cycle.
  task automatic pull(input string tag, input logic [AW-1:0] expAddr, input logic [1:0] clrMask);
    @(negedge clk);
    consumerReq = 1'b1;
    #1;
    check({tag, " R3 memRdEn"}, 32'(memRdEn), 32'd1);
    check({tag, " R4 memAddr"}, 32'(memAddr), 32'(expAddr));
    @(negedge clk);
    consumerReq = 1'b0;
    check({tag, " R3 ack"}, 32'(consumerAck), 32'd1);
    check({tag, " R3 data"}, consumerData, memWord(expAddr));
    if (clrMask != 2'b00) begin
      regSel = 3'd3; regWrData = 32'(clrMask); regWrEn = 1'b1;
    end
    @(negedge clk);
    regWrEn = 1'b0;
    check({tag, " R3 ack one cycle"}, 32'(consumerAck), 32'd0);
  endtask

  // addr, half after, full after
  localparam logic [17:0] VEC [8] = '{
    {16'h0040, 1'b0, 1'b0}, {16'h0044, 1'b1, 1'b0},
    {16'h0048, 1'b1, 1'b0}, {16'h004C, 1'b1, 1'b1},
    {16'h0040, 1'b1, 1'b1}, {16'h0044, 1'b1, 1'b1},
    {16'h0048, 1'b1, 1'b1}, {16'h004C, 1'b1, 1'b1}
  };

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack", 32'(consumerAck), 32'd0);
    check("R1 memRdEn", 32'(memRdEn), 32'd0);
    check("R1 flags", {30'd0, irqFull, irqHalf}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    regRead(3'd2, rd); check("R1 enable", rd, 32'd0);
    regRead(3'd4, rd); check("R1 curAddr", rd, 32'd0);

    // R2 register readback, R12 current address read-only
    regWrite(3'd0, 32'h0040);
    regWrite(3'd1, 32'd16);
    regRead(3'd0, rd); check("R2 base", rd, 32'h40);
    regRead(3'd1, rd); check("R2 length", rd, 32'd16);
    regRead(3'd6, rd); check("R2 unused select", rd, 32'd0);
    regWrite(3'd4, 32'h1234);
    regRead(3'd4, rd); check("R12 curAddr unchanged", rd, 32'd0);

    // R10 requests ignored while disabled
    @(negedge clk);
    consumerReq = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R10 no read when off", 32'(memRdEn), 32'd0);
      @(negedge clk);
      check("R10 no ack when off", 32'(consumerAck), 32'd0);
    end
    consumerReq = 1'b0;
    regRead(3'd4, rd); check("R10 address held", rd, 32'd0);

    // R11 enable loads base
    regWrite(3'd2, 32'd1);
    regRead(3'd2, rd); check("R2 enable readback", rd, 32'd1);
    regRead(3'd4, rd); check("R11 addr at base", rd, 32'h40);

    // Table: two passes (R4 R5 R6 R7)
    for (int i = 0; i < 8; i++) begin
      pull("R5 table", VEC[i][17:2], 2'b00);
      check("R6 half flag", 32'(irqHalf), 32'(VEC[i][1]));
      check("R7 full flag", 32'(irqFull), 32'(VEC[i][0]));
      regRead(3'd3, rd); check("R2 status bits", rd, {30'd0, VEC[i][0], VEC[i][1]});
    end
    regRead(3'd4, rd); check("R5 back at base", rd, 32'h40);

    // R8 write-one-to-clear
    regWrite(3'd3, 32'd0);
    regRead(3'd3, rd); check("R8 zero write no effect", rd, 32'd3);
    regWrite(3'd3, 32'd1);
    regRead(3'd3, rd); check("R8 clear half only", rd, 32'd2);
    regWrite(3'd3, 32'd2);
    regRead(3'd3, rd); check("R8 clear full", rd, 32'd0);

    // R9 event beats clear in same cycle
    pull("R9 p1", 16'h0040, 2'b00);
    pull("R9 p2", 16'h0044, 2'b01);
    check("R9 half kept", 32'(irqHalf), 32'd1);
    pull("R9 p3", 16'h0048, 2'b00);
    pull("R9 p4", 16'h004C, 2'b10);
    check("R9 full kept", 32'(irqFull), 32'd1);
    regWrite(3'd3, 32'd3);
    check("R8 both cleared", {30'd0, irqFull, irqHalf}, 32'd0);

    // R11 restart mid pass
    pull("R11 p1", 16'h0040, 2'b00);
    regWrite(3'd2, 32'd0);
    regRead(3'd4, rd); check("R10 addr kept on disable", rd, 32'h44);
    regWrite(3'd2, 32'd1);
    regRead(3'd4, rd); check("R11 restart at base", rd, 32'h40);
    pull("R11 q1", 16'h0040, 2'b00);
    pull("R11 q2", 16'h0044, 2'b00);
    pull("R11 q3", 16'h0048, 2'b00);
    check("R11 no full before end", 32'(irqFull), 32'd0);
    pull("R11 q4", 16'h004C, 2'b00);
    check("R11 full at end", 32'(irqFull), 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule